// File: doc/BRIEF.md
# Voice Channel Register Decoder

This block receives register writes aimed at a bank of playback voices and turns them into per-voice parameter state. Every write carries a window select, a byte offset within that window and a data word. The upper bits of the offset pick a voice on a 128-byte stride, and the low seven bits pick the register inside that voice. Each window covers half of the voices. Window 0 reaches the lower half and window 1 reaches the upper half.

Each voice holds a 21-bit sample start address, a loop enable, a sample format code, a loop start address and a pitch word in floating-point form. The start address is split across two registers. The configuration register supplies its top five bits, and a second register supplies its low sixteen bits. Writing one half leaves the other half unchanged. A configuration write also carries a key command, which can raise a one-cycle start or stop pulse for the addressed voice. Sample fetching, envelopes, mixing and read-back are handled outside this block.

Writes arrive on a valid/ready port. `wr_ready` is held high at all times after reset, so the block never applies back-pressure. A write takes effect in the clock cycle where `wr_valid` is sampled high, and any data presented while `wr_valid` is low is discarded.

Top module: `voice_reg_decoder`

## Requirements
- R1: While reset is asserted and right after it, every voice register reads zero and no start or stop pulse is high.
- R2: The target voice is window × (NUM_CH/2) + (offset >> 7), and the register is offset mod 128. A write changes only the addressed voice.
- R3: A write to register 0x00 sets start address bits 20:16 from data bits 4:0 and keeps start address bits 15:0.
- R4: A write to register 0x04 sets start address bits 15:0 from data bits 15:0 and keeps start address bits 20:16.
- R5: On a 0x00 write, data bits 8:7 set the format code: 0 gives 0 (16-bit PCM), 1 gives 1 (8-bit PCM), and 2 or 3 give 2 (ADPCM). The format code never reads 3.
- R6: On a 0x00 write, data bit 9 sets the loop enable.
- R7: On a 0x00 write, data bits 15:14 hold the key command. A value of 3 raises that voice's `key_on` bit, and a value of 2 raises its `key_off` bit. The pulse is high for exactly the cycle after the write. Values 0 and 1 raise nothing. At most one voice pulses at a time.
- R8: A write to register 0x08 sets the loop start address from data bits LOOP_W-1:0.
- R9: A write to register 0x18 sets the pitch word from data bits FREQ_W-1:0.
- R10: Writes to any other register, and bus activity while `wr_valid` is low, leave every output unchanged.
- R11: `wr_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write is presented |
| wr_ready | output | 1 | Always high; the block never stalls |
| wr_win | input | 1 | Window select: 0 for the lower voices, 1 for the upper voices |
| wr_offs | input | OFFS_W | Byte offset within the window |
| wr_data | input | DATA_W | Write data |
| v_start | output | NUM_CH*21 | Start address per voice, voice i at bits [i*21 +: 21] |
| v_loop_en | output | NUM_CH | Loop enable per voice |
| v_fmt | output | NUM_CH*2 | Format code per voice |
| v_loop_start | output | NUM_CH*LOOP_W | Loop start address per voice |
| v_freq | output | NUM_CH*FREQ_W | Pitch word per voice |
| key_on | output | NUM_CH | One-cycle start pulse per voice |
| key_off | output | NUM_CH | One-cycle stop pulse per voice |

## Verification
The bench builds the decoder with NUM_CH=8, so each window holds four voices and the offset is 9 bits wide. At that size, every voice in both windows receives every decoded register, and every undecoded register the sweep touches. The configuration register is driven with all sixteen combinations of key command and format field, each with the loop bit both clear and set. After every write, the bench compares the state of all eight voices against its own arithmetic model. This exposes any misrouting across windows, and any spill from one half of the start address into the other.

// File: rtl/voice_dec_pkg.sv
package voice_dec_pkg;

  localparam int START_W    = 21;
  localparam int START_LO_W = 16;
  localparam int START_HI_W = START_W - START_LO_W;
  localparam int STRIDE_LOG2 = 7;

  typedef enum logic [1:0] {
    FMT_PCM16 = 2'd0,
    FMT_PCM8  = 2'd1,
    FMT_ADPCM = 2'd2
  } fmt_e;

  localparam logic [STRIDE_LOG2-1:0] REG_CFG      = 7'h00;
  localparam logic [STRIDE_LOG2-1:0] REG_START_LO = 7'h04;
  localparam logic [STRIDE_LOG2-1:0] REG_LOOP     = 7'h08;
  localparam logic [STRIDE_LOG2-1:0] REG_FREQ     = 7'h18;

  localparam logic [1:0] KEY_STOP  = 2'd2;
  localparam logic [1:0] KEY_START = 2'd3;

  localparam int CFG_FMT_LSB  = 7;
  localparam int CFG_LOOP_BIT = 9;
  localparam int CFG_KEY_LSB  = 14;

endpackage

// File: rtl/voice_addr_decode.sv
module voice_addr_decode
  import voice_dec_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int WIN_CH = NUM_CH / 2,
  localparam int OFFS_W = $clog2(WIN_CH) + STRIDE_LOG2,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic                   win,
  input  logic [OFFS_W-1:0]      offs,
  output logic [NUM_CH-1:0]      ch_sel,
  output logic [STRIDE_LOG2-1:0] reg_sel
);

  logic [CH_W-1:0] ch_idx;

  // window select becomes the top index bit: win*WIN_CH + offs>>7
  assign ch_idx  = {win, offs[OFFS_W-1:STRIDE_LOG2]};
  assign reg_sel = offs[STRIDE_LOG2-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = fire && (ch_idx == CH_W'(i));
  end

  AST_ONE_VOICE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel)) else $error("more than one voice selected"); // R2

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (ch_sel == '0)) else $error("voice selected without a write"); // R10

endmodule

// File: rtl/voice_chan_regs.sv
module voice_chan_regs
  import voice_dec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOOP_W = 16,
  parameter int FREQ_W = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic [STRIDE_LOG2-1:0] reg_sel,
  input  logic [DATA_W-1:0]      data,
  output logic [START_W-1:0]     start,
  output logic                   loop_en,
  output logic [1:0]             fmt,
  output logic [LOOP_W-1:0]      loop_start,
  output logic [FREQ_W-1:0]      freq,
  output logic                   key_on,
  output logic                   key_off
);

  logic [START_W-1:0] start_q;
  logic               loop_q;
  fmt_e               fmt_q, fmt_d;
  logic [LOOP_W-1:0]  lstart_q;
  logic [FREQ_W-1:0]  freq_q;
  logic               on_q, off_q;
  logic [1:0]         key_cmd;
  logic               wr_cfg, wr_lo, wr_loop, wr_freq;
  logic [DATA_W-1:0]  unused_data_bits;

  assign unused_data_bits = data;

  assign wr_cfg  = sel && (reg_sel == REG_CFG);
  assign wr_lo   = sel && (reg_sel == REG_START_LO);
  assign wr_loop = sel && (reg_sel == REG_LOOP);
  assign wr_freq = sel && (reg_sel == REG_FREQ);

  assign key_cmd = data[CFG_KEY_LSB +: 2];

  always_comb begin
    if (data[CFG_FMT_LSB + 1])  fmt_d = FMT_ADPCM;
    else if (data[CFG_FMT_LSB]) fmt_d = FMT_PCM8;
    else                        fmt_d = FMT_PCM16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      loop_q   <= 1'b0;
      fmt_q    <= FMT_PCM16;
      lstart_q <= '0;
      freq_q   <= '0;
      on_q     <= 1'b0;
      off_q    <= 1'b0;
    end else begin
      on_q  <= wr_cfg && (key_cmd == KEY_START);
      off_q <= wr_cfg && (key_cmd == KEY_STOP);
      if (wr_cfg) begin
        start_q[START_W-1:START_LO_W] <= data[START_HI_W-1:0];
        loop_q <= data[CFG_LOOP_BIT];
        fmt_q  <= fmt_d;
      end
      if (wr_lo)   start_q[START_LO_W-1:0] <= data[START_LO_W-1:0];
      if (wr_loop) lstart_q <= data[LOOP_W-1:0];
      if (wr_freq) freq_q   <= data[FREQ_W-1:0];
    end
  end

  assign start      = start_q;
  assign loop_en    = loop_q;
  assign fmt        = fmt_q;
  assign loop_start = lstart_q;
  assign freq       = freq_q;
  assign key_on     = on_q;
  assign key_off    = off_q;

  AST_CFG_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> start_q[START_LO_W-1:0] == $past(start_q[START_LO_W-1:0]))
    else $error("config write disturbed low start bits"); // R3

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> start_q[START_W-1:START_LO_W] == $past(start_q[START_W-1:START_LO_W]))
    else $error("low start write disturbed high bits"); // R4

  AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q != 2'd3) else $error("illegal format code"); // R5

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_q && off_q)) else $error("start and stop together"); // R7

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> !on_q && !off_q) else $error("pulse without config write"); // R7

  AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(start_q) && $stable(lstart_q) && $stable(freq_q) && $stable(loop_q))
    else $error("state moved without a write"); // R10

endmodule

// File: rtl/voice_reg_decoder.sv
module voice_reg_decoder
  import voice_dec_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  parameter int LOOP_W = 16,
  parameter int FREQ_W = 15,
  localparam int WIN_CH = NUM_CH / 2,
  localparam int OFFS_W = $clog2(WIN_CH) + STRIDE_LOG2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic                       wr_win,
  input  logic [OFFS_W-1:0]          wr_offs,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_CH*START_W-1:0]  v_start,
  output logic [NUM_CH-1:0]          v_loop_en,
  output logic [NUM_CH*2-1:0]        v_fmt,
  output logic [NUM_CH*LOOP_W-1:0]   v_loop_start,
  output logic [NUM_CH*FREQ_W-1:0]   v_freq,
  output logic [NUM_CH-1:0]          key_on,
  output logic [NUM_CH-1:0]          key_off
);

  logic                   fire;
  logic [NUM_CH-1:0]      ch_sel;
  logic [STRIDE_LOG2-1:0] reg_sel;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  voice_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .win     (wr_win),
    .offs    (wr_offs),
    .ch_sel  (ch_sel),
    .reg_sel (reg_sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_voice
    voice_chan_regs #(
      .DATA_W (DATA_W),
      .LOOP_W (LOOP_W),
      .FREQ_W (FREQ_W)
    ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (ch_sel[i]),
      .reg_sel    (reg_sel),
      .data       (wr_data),
      .start      (v_start[i*START_W +: START_W]),
      .loop_en    (v_loop_en[i]),
      .fmt        (v_fmt[i*2 +: 2]),
      .loop_start (v_loop_start[i*LOOP_W +: LOOP_W]),
      .freq       (v_freq[i*FREQ_W +: FREQ_W]),
      .key_on     (key_on[i]),
      .key_off    (key_off[i])
    );
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_on)) else $error("several start pulses"); // R7

  AST_ONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_off)) else $error("several stop pulses"); // R7

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (key_on == '0) && (key_off == '0)) else $error("pulse without write"); // R7

endmodule

// File: tb/test_voice_reg_decoder.sv
`timescale 1ns/1ps
module test_voice_reg_decoder;

  localparam int NUM_CH = 8;
  localparam int WIN_CH = NUM_CH / 2;
  localparam int OFFS_W = $clog2(WIN_CH) + 7;
  localparam int DATA_W = 32;
  localparam int LOOP_W = 16;
  localparam int FREQ_W = 15;
  localparam int SW     = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic wr_win = 1'b0;
  logic [OFFS_W-1:0] wr_offs = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NUM_CH*SW-1:0]     v_start;
  logic [NUM_CH-1:0]        v_loop_en;
  logic [NUM_CH*2-1:0]      v_fmt;
  logic [NUM_CH*LOOP_W-1:0] v_loop_start;
  logic [NUM_CH*FREQ_W-1:0] v_freq;
  logic [NUM_CH-1:0]        key_on, key_off;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [SW-1:0]     m_start  [NUM_CH];
  logic              m_loop   [NUM_CH];
  logic [1:0]        m_fmt    [NUM_CH];
  logic [LOOP_W-1:0] m_lstart [NUM_CH];
  logic [FREQ_W-1:0] m_freq   [NUM_CH];
  logic [NUM_CH-1:0] m_on, m_off;

  always #2.5 clk = ~clk;

  voice_reg_decoder #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .LOOP_W(LOOP_W), .FREQ_W(FREQ_W)
  ) i_voice_reg_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_win(wr_win), .wr_offs(wr_offs), .wr_data(wr_data),
    .v_start(v_start), .v_loop_en(v_loop_en), .v_fmt(v_fmt),
    .v_loop_start(v_loop_start), .v_freq(v_freq),
    .key_on(key_on), .key_off(key_off)
  );

  task automatic check_all(input string tag);
    vectors++;
    if (wr_ready !== 1'b1 && rst_n) begin
      miscompares++;
      $display("FAIL %s R11 ready act=%b exp=1", tag, wr_ready);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (v_start[c*SW +: SW] !== m_start[c]) begin
        miscompares++;
        $display("FAIL %s R2 voice%0d start act=%h exp=%h", tag, c, v_start[c*SW +: SW], m_start[c]);
      end
      if (v_loop_en[c] !== m_loop[c]) begin
        miscompares++;
        $display("FAIL %s R6 voice%0d loop act=%b exp=%b", tag, c, v_loop_en[c], m_loop[c]);
      end
      if (v_fmt[c*2 +: 2] !== m_fmt[c]) begin
        miscompares++;
        $display("FAIL %s R5 voice%0d fmt act=%0d exp=%0d", tag, c, v_fmt[c*2 +: 2], m_fmt[c]);
      end
      if (v_loop_start[c*LOOP_W +: LOOP_W] !== m_lstart[c]) begin
        miscompares++;
        $display("FAIL %s R8 voice%0d lstart act=%h exp=%h", tag, c, v_loop_start[c*LOOP_W +: LOOP_W], m_lstart[c]);
      end
      if (v_freq[c*FREQ_W +: FREQ_W] !== m_freq[c]) begin
        miscompares++;
        $display("FAIL %s R9 voice%0d freq act=%h exp=%h", tag, c, v_freq[c*FREQ_W +: FREQ_W], m_freq[c]);
      end
    end
    if (key_on !== m_on || key_off !== m_off) begin
      miscompares++;
      $display("FAIL %s R7 pulses act=%b/%b exp=%b/%b", tag, key_on, key_off, m_on, m_off);
    end
  endtask

  task automatic wr(input bit w, input int off, input logic [DATA_W-1:0] d, input string tag);
    int c;
    int r;
    c = w * WIN_CH + (off >> 7);
    r = off % 128;
    m_on = '0;
    m_off = '0;
    case (r)
      'h00: begin
        m_start[c][20:16] = d[4:0];
        m_loop[c] = d[9];
        m_fmt[c] = d[8] ? 2'd2 : (d[7] ? 2'd1 : 2'd0);
        if (d[15:14] == 2'd3) m_on[c] = 1'b1;
        if (d[15:14] == 2'd2) m_off[c] = 1'b1;
      end
      'h04: m_start[c][15:0] = d[15:0];
      'h08: m_lstart[c] = d[LOOP_W-1:0];
      'h18: m_freq[c] = d[FREQ_W-1:0];
      default: ;
    endcase
    @(negedge clk);
    wr_valid = 1'b1;
    wr_win = w;
    wr_offs = OFFS_W'(off);
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    m_on = '0;
    m_off = '0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      m_start[c] = '0; m_loop[c] = 1'b0; m_fmt[c] = '0;
      m_lstart[c] = '0; m_freq[c] = '0;
    end
    m_on = '0;
    m_off = '0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R2 R4 R8 R9: every data register of every voice in both windows
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < WIN_CH; c++) begin
        int base;
        base = c * 128;
        wr(w[0], base + 'h04, 32'hC3A5_0000 ^ ((w * WIN_CH + c) * 32'h0001_1357), "R2 R4 start low");
        wr(w[0], base + 'h08, 32'h7E00_0000 ^ ((w * WIN_CH + c) * 32'h0002_2469), "R2 R8 loop start");
        wr(w[0], base + 'h18, 32'hFFFF_8000 ^ ((w * WIN_CH + c) * 32'h0000_0B3D), "R2 R9 freq");
      end

    // R3 R5 R6 R7: every key command, format field and loop bit per voice
    for (int v = 0; v < NUM_CH; v++)
      for (int key = 0; key < 4; key++)
        for (int f = 0; f < 4; f++)
          for (int lp = 0; lp < 2; lp++) begin
            logic [31:0] d;
            d = 32'((v * 4099) << 16);
            d[4:0]   = 5'((v * 7 + f * 3 + key + lp * 11) % 32);
            d[6:5]   = 2'(v);
            d[8:7]   = 2'(f);
            d[9]     = lp[0];
            d[13:10] = 4'((key * 5 + v) % 16);
            d[15:14] = 2'(key);
            wr(v >= WIN_CH, (v % WIN_CH) * 128, d, "R3 R5 R6 R7 config");
            if (key >= 2) idle_check("R7 pulse clears");
          end

    // R4 after R3: low half rewrite keeps the high half set by config
    for (int v = 0; v < NUM_CH; v++)
      wr(v >= WIN_CH, (v % WIN_CH) * 128 + 'h04, 32'h0000_1111 * 32'(v + 1), "R4 keeps high bits");

    // R10: undecoded registers
    for (int v = 0; v < NUM_CH; v++) begin
      int offs_list [7];
      offs_list = '{'h0C, 'h10, 'h14, 'h1C, 'h24, 'h28, 'h7C};
      foreach (offs_list[k])
        wr(v >= WIN_CH, (v % WIN_CH) * 128 + offs_list[k], 32'hFFFF_FFFF, "R10 undecoded");
    end

    // R10: bus activity with valid low
    for (int v = 0; v < NUM_CH; v++) begin
      @(negedge clk);
      wr_win = (v >= WIN_CH);
      wr_offs = OFFS_W'((v % WIN_CH) * 128);
      wr_data = 32'hFFFF_C3FF;
      @(negedge clk);
      m_on = '0;
      m_off = '0;
      check_all("R10 valid low");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule